// File: doc/BRIEF.md
# Masked Interrupt Flag Register

This block gathers the interrupt requests of a small microcontroller's peripherals into one eight-bit status register. Each bit is a sticky flag raised by a hardware event: a pulse from the main timer, from one of three auxiliary timers, or from either of two pulse-width timers. Two flags come from pins: a falling edge on an asynchronous external interrupt pin, and any change on an asynchronous input port. Both pass through two-flop synchronizers before the edge or change is detected.

Software reaches the block through a small register interface. Writing the status register can only clear flags. Reading it returns the flags ANDed with an interrupt mask register, and that same masked value drives a single interrupt request output. A wake-enable register gates three wake-from-sleep sources independently: the port-change flag, a comparator event and a low-voltage-detect event. Their OR is the wake request output.

Top module: `irq_flag_reg`

## Requirements
- R1: Status bit positions, bit 7 down to bit 0: low-pulse-width timer underflow, high-pulse-width timer underflow, timer C overflow, timer B overflow, timer A overflow, external interrupt, port change, main timer overflow. A timer event input that is high at a rising clock edge sets its flag at that edge. A 1 means a request is pending.
- R2: The external interrupt pin is synchronized by two flops. A high-to-low transition sets flag bit 2 on the third rising edge after the pin first reads low. A low-to-high transition sets nothing.
- R3: The port is synchronized by two flops. Any change in any port bit sets flag bit 1, with the same three-edge latency as R2.
- R4: A write to address 0 clears every flag whose write-data bit is 0 and leaves alone every flag whose write-data bit is 1. No write can set a flag.
- R5: If a hardware set and a software clear reach the same flag at the same edge, the flag ends up set.
- R6: Reads are combinational. Address 0 returns flags AND mask. Address 1 is the read/write mask register. Address 2 is the read/write wake-enable register in bits 2:0, with bits 7:3 reading 0. Address 3 reads 0.
- R7: `irq` is high exactly when some flag and its mask bit are both 1.
- R8: `wake_req` = (enable bit 0 AND flag bit 1) OR (enable bit 1 AND `cmp_evt`) OR (enable bit 2 AND `lvd_evt`). `cmp_evt` and `lvd_evt` act combinationally.
- R9: Reset clears the flags, the mask and the wake enables. For three clock edges after reset is released, no pin edge or port change is detected, so whatever levels the pins hold at reset raise no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tmr_ovf | input | 1 | Main timer overflow pulse |
| tmra_ovf | input | 1 | Timer A overflow pulse |
| tmrb_ovf | input | 1 | Timer B overflow pulse |
| tmrc_ovf | input | 1 | Timer C overflow pulse |
| hpw_unf | input | 1 | High-pulse-width timer underflow pulse |
| lpw_unf | input | 1 | Low-pulse-width timer underflow pulse |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| port_in | input | PORT_W | Asynchronous monitored input port |
| cmp_evt | input | 1 | Comparator wake event |
| lvd_evt | input | 1 | Low-voltage-detect wake event |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| irq | output | 1 | Interrupt request |
| wake_req | output | 1 | Wake-from-sleep request |

## Verification
The assertions check on every cycle that no write can raise a flag, that write-zero-to-clear keeps exactly the bits written as 1, that a set event always lands even when a clear arrives at the same edge, and that the status read and `irq` track flags AND mask. They also check that a wake request always traces back to an enabled source, and that reset clears the state. Only the bench's scenarios can show the pin timing: the three-edge latency through the synchronizers, that a rising pin edge is ignored, and the warm-up window that hides the pin levels present at reset. The random phase compares every cycle against a model built from the requirements.

// File: rtl/irq_flag_pkg.sv
// Package irq_flag_pkg
// Shared constants for the masked interrupt flag register: flag bit
// positions, register addresses and wake-enable bit positions.
package irq_flag_pkg;
    localparam int FLAG_W = 8;
    localparam int ADDR_W = 2;
    localparam int WEN_W  = 3;

    // Flag bit positions (the order software decodes)
    localparam int F_TMR  = 0;
    localparam int F_PCHG = 1;
    localparam int F_EXT  = 2;
    localparam int F_TMRA = 3;
    localparam int F_TMRB = 4;
    localparam int F_TMRC = 5;
    localparam int F_HPW  = 6;
    localparam int F_LPW  = 7;

    // Register addresses
    localparam logic [ADDR_W-1:0] A_STATUS = 2'd0;
    localparam logic [ADDR_W-1:0] A_MASK   = 2'd1;
    localparam logic [ADDR_W-1:0] A_WEN    = 2'd2;

    // Wake-enable bit positions
    localparam int W_PCHG = 0;
    localparam int W_CMP  = 1;
    localparam int W_LVD  = 2;
endpackage

// File: rtl/irq_sync.sv
// Module irq_sync
// Multi-flop synchronizer for a vector of asynchronous inputs.
// Assumes each bit is independent: no multi-bit coherence is promised.
module irq_sync #(
    parameter int W       = 1,
    parameter int STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stg [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            // One flop stage of the synchronizer chain
            always_ff @(posedge clk) begin
                if (!rst_n) stg[i] <= {W{RST_VAL}};
                else if (i == 0) stg[i] <= d_async;
                else stg[i] <= stg[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign q_sync = stg[STAGES-1];
endmodule

// File: rtl/irq_edge_det.sv
// Module irq_edge_det
// Detects a falling edge on the synchronized external pin and any change on
// the synchronized port. Detection is held off until the synchronizer chain
// and the history flops hold real pin samples (STAGES+1 edges after reset).
module irq_edge_det #(
    parameter int PORT_W = 8,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_s,
    input  logic [PORT_W-1:0] port_s,
    output logic              ext_fall,
    output logic              port_chg
);
    localparam int WARM   = STAGES + 1;
    localparam int WCNT_W = $clog2(WARM + 1);

    logic              ext_prev;
    logic [PORT_W-1:0] port_prev;
    logic [WCNT_W-1:0] warm_cnt;
    logic              armed;

    // History of the synchronized inputs, one cycle back
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_prev  <= 1'b1;
            port_prev <= '0;
        end else begin
            ext_prev  <= ext_s;
            port_prev <= port_s;
        end
    end

    // Warm-up counter that arms detection once history is valid
    always_ff @(posedge clk) begin
        if (!rst_n) warm_cnt <= '0;
        else if (!armed) warm_cnt <= warm_cnt + 1'b1;
    end

    assign armed    = (warm_cnt == WCNT_W'(WARM));
    assign ext_fall = armed & ext_prev & ~ext_s;
    assign port_chg = armed & (port_prev != port_s);
endmodule

// File: rtl/irq_flag_core.sv
// Module irq_flag_core
// Sticky flag register. Hardware set bits OR in every cycle; a software
// write clears bits written as 0. A set beats a clear on the same bit.
module irq_flag_core #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] hw_set,
    input  logic         clr_we,
    input  logic [W-1:0] clr_keep,
    output logic [W-1:0] flags
);
    logic [W-1:0] keep_v;

    // Bits to retain this cycle: all, or only those written as 1
    always_comb keep_v = clr_we ? clr_keep : {W{1'b1}};

    // Flag state update with set priority
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else flags <= (flags & keep_v) | hw_set;
    end
endmodule

// File: rtl/irq_regif.sv
// Module irq_regif
// Register interface: address decode, mask and wake-enable registers,
// combinational read mux, interrupt and wake request generation.
module irq_regif
    import irq_flag_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [FLAG_W-1:0] reg_wdata,
    input  logic [FLAG_W-1:0] flags,
    input  logic              cmp_evt,
    input  logic              lvd_evt,
    output logic              clr_we,
    output logic [FLAG_W-1:0] mask,
    output logic [WEN_W-1:0]  wen,
    output logic [FLAG_W-1:0] reg_rdata,
    output logic              irq,
    output logic              wake_req
);
    logic [FLAG_W-1:0] masked;

    assign clr_we = reg_wr && (reg_addr == A_STATUS);
    assign masked = flags & mask;

    // Mask and wake-enable registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '0;
            wen  <= '0;
        end else if (reg_wr) begin
            if (reg_addr == A_MASK) mask <= reg_wdata;
            if (reg_addr == A_WEN)  wen  <= reg_wdata[WEN_W-1:0];
        end
    end

    // Read data mux
    always_comb begin
        case (reg_addr)
            A_STATUS: reg_rdata = masked;
            A_MASK:   reg_rdata = mask;
            A_WEN:    reg_rdata = {{(FLAG_W-WEN_W){1'b0}}, wen};
            default:  reg_rdata = '0;
        endcase
    end

    // Interrupt and wake request outputs
    always_comb begin
        irq      = |masked;
        wake_req = (wen[W_PCHG] & flags[F_PCHG])
                 | (wen[W_CMP]  & cmp_evt)
                 | (wen[W_LVD]  & lvd_evt);
    end
endmodule

// File: rtl/irq_flag_reg.sv
// Module irq_flag_reg
// Top of the masked interrupt flag register. Synchronizes the pin inputs,
// detects pin events, keeps sticky flags and serves the register interface.
// Assumes timer event inputs are synchronous to clk.
module irq_flag_reg
    import irq_flag_pkg::*;
#(
    parameter int PORT_W = 8,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tmr_ovf,
    input  logic              tmra_ovf,
    input  logic              tmrb_ovf,
    input  logic              tmrc_ovf,
    input  logic              hpw_unf,
    input  logic              lpw_unf,
    input  logic              ext_pin,
    input  logic [PORT_W-1:0] port_in,
    input  logic              cmp_evt,
    input  logic              lvd_evt,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              irq,
    output logic              wake_req
);
    logic              ext_s;
    logic [PORT_W-1:0] port_s;
    logic              ext_fall;
    logic              port_chg;
    logic [FLAG_W-1:0] hw_set;
    logic [FLAG_W-1:0] flags;
    logic [FLAG_W-1:0] mask;
    logic [WEN_W-1:0]  wen;
    logic              clr_we;

    irq_sync #(.W(1), .STAGES(STAGES), .RST_VAL(1'b1)) u_ext_sync (
        .clk(clk), .rst_n(rst_n), .d_async(ext_pin), .q_sync(ext_s)
    );

    irq_sync #(.W(PORT_W), .STAGES(STAGES), .RST_VAL(1'b0)) u_port_sync (
        .clk(clk), .rst_n(rst_n), .d_async(port_in), .q_sync(port_s)
    );

    irq_edge_det #(.PORT_W(PORT_W), .STAGES(STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .ext_s(ext_s), .port_s(port_s),
        .ext_fall(ext_fall), .port_chg(port_chg)
    );

    // Gather set events into flag positions
    always_comb begin
        hw_set         = '0;
        hw_set[F_TMR]  = tmr_ovf;
        hw_set[F_PCHG] = port_chg;
        hw_set[F_EXT]  = ext_fall;
        hw_set[F_TMRA] = tmra_ovf;
        hw_set[F_TMRB] = tmrb_ovf;
        hw_set[F_TMRC] = tmrc_ovf;
        hw_set[F_HPW]  = hpw_unf;
        hw_set[F_LPW]  = lpw_unf;
    end

    irq_flag_core #(.W(FLAG_W)) u_core (
        .clk(clk), .rst_n(rst_n), .hw_set(hw_set), .clr_we(clr_we),
        .clr_keep(reg_wdata), .flags(flags)
    );

    irq_regif u_regif (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .flags(flags), .cmp_evt(cmp_evt),
        .lvd_evt(lvd_evt), .clr_we(clr_we), .mask(mask), .wen(wen),
        .reg_rdata(reg_rdata), .irq(irq), .wake_req(wake_req)
    );
endmodule

// File: rtl/irq_flag_reg_chk.sv
// Module irq_flag_reg_chk
// Property checker bound to irq_flag_reg; observes internal flag, mask,
// enable and set vectors alongside the ports.
module irq_flag_reg_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] hw_set,
    input logic [7:0] flags,
    input logic [7:0] mask,
    input logic [2:0] wen,
    input logic       reg_wr,
    input logic [1:0] reg_addr,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic       irq,
    input logic       wake_req,
    input logic       cmp_evt,
    input logic       lvd_evt
);
    // R4: without a hardware set, no flag rises
    p_no_sw_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_set == 8'h00) |=> ((flags & ~$past(flags)) == 8'h00));

    // R4: write-zero-to-clear keeps exactly the bits written as 1
    p_w0c_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd0 && hw_set == 8'h00)
        |=> (flags == ($past(flags) & $past(reg_wdata))));

    // R5: every set event lands, even against a clear
    p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_set != 8'h00) |=> ((flags & $past(hw_set)) == $past(hw_set)));

    // R6: status read is flags AND mask
    p_read_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 2'd0) |-> (reg_rdata == (flags & mask)));

    // R7: interrupt request follows the masked flags
    p_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq == ((flags & mask) != 8'h00));

    // R8: a wake request needs an enabled active source
    p_wake_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> ((wen[0] && flags[1]) || (wen[1] && cmp_evt) || (wen[2] && lvd_evt)));

    // R9: state is clear the cycle after reset
    p_reset_r9: assert property (@(posedge clk)
        !rst_n |=> (flags == 8'h00 && mask == 8'h00 && wen == 3'd0));
endmodule

bind irq_flag_reg irq_flag_reg_chk u_chk (
    .clk(clk), .rst_n(rst_n), .hw_set(hw_set), .flags(flags), .mask(mask),
    .wen(wen), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq), .wake_req(wake_req),
    .cmp_evt(cmp_evt), .lvd_evt(lvd_evt)
);

// File: tb/irq_flag_reg_bench.sv
module irq_flag_reg_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tmr_ovf = 0, tmra_ovf = 0, tmrb_ovf = 0, tmrc_ovf = 0;
    logic       hpw_unf = 0, lpw_unf = 0;
    logic       ext_pin = 1'b0;
    logic [7:0] port_in = 8'hA5;
    logic       cmp_evt = 0, lvd_evt = 0;
    logic       reg_wr = 0;
    logic [1:0] reg_addr = 0;
    logic [7:0] reg_wdata = 0;
    logic [7:0] reg_rdata;
    logic       irq, wake_req;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    irq_flag_reg u_irq_flag_reg (
        .clk(clk), .rst_n(rst_n), .tmr_ovf(tmr_ovf), .tmra_ovf(tmra_ovf),
        .tmrb_ovf(tmrb_ovf), .tmrc_ovf(tmrc_ovf), .hpw_unf(hpw_unf),
        .lpw_unf(lpw_unf), .ext_pin(ext_pin), .port_in(port_in),
        .cmp_evt(cmp_evt), .lvd_evt(lvd_evt), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .wake_req(wake_req)
    );

    // Reference model from the requirements
    logic       m_e1, m_e2, m_ep;
    logic [7:0] m_p1, m_p2, m_pp;
    logic [1:0] m_warm;
    logic [7:0] m_flags, m_mask;
    logic [2:0] m_wen;
    logic [7:0] m_set, m_keep;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_e1 <= 1; m_e2 <= 1; m_ep <= 1;
            m_p1 <= 0; m_p2 <= 0; m_pp <= 0;
            m_warm <= 0; m_flags <= 0; m_mask <= 0; m_wen <= 0;
        end else begin
            m_set = {lpw_unf, hpw_unf, tmrc_ovf, tmrb_ovf, tmra_ovf,
                     (m_warm == 2'd3) && m_ep && !m_e2,
                     (m_warm == 2'd3) && (m_p2 != m_pp), tmr_ovf};
            m_keep = (reg_wr && reg_addr == 2'd0) ? reg_wdata : 8'hFF;
            m_flags <= (m_flags & m_keep) | m_set;
            if (reg_wr && reg_addr == 2'd1) m_mask <= reg_wdata;
            if (reg_wr && reg_addr == 2'd2) m_wen <= reg_wdata[2:0];
            m_e1 <= ext_pin; m_e2 <= m_e1; m_ep <= m_e2;
            m_p1 <= port_in; m_p2 <= m_p1; m_pp <= m_p2;
            if (m_warm != 2'd3) m_warm <= m_warm + 2'd1;
        end
    end

    function automatic logic exp_wake(logic [2:0] w, logic [7:0] f, logic c, logic l);
        return (w[0] & f[1]) | (w[1] & c) | (w[2] & l);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare status read, irq and wake against the model
    task automatic check_all(string tag);
        reg_addr = 2'd0;
        #1;
        chk({tag, " R6 status"}, reg_rdata, m_flags & m_mask);
        chk({tag, " R7 irq"}, irq, |(m_flags & m_mask));
        chk({tag, " R8 wake"}, wake_req, exp_wake(m_wen, m_flags, cmp_evt, lvd_evt));
    endtask

    task automatic check_reg(logic [1:0] a, logic [7:0] exp, string tag);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    // Advance one cycle, drop pulse drives, compare against the model
    task automatic tick(string tag);
        @(posedge clk);
        @(negedge clk);
        reg_wr = 0;
        {tmr_ovf, tmra_ovf, tmrb_ovf, tmrc_ovf, hpw_unf, lpw_unf} = '0;
        check_all(tag);
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [5:0] evs;
        void'($urandom(32'h1234_5678));
        repeat (3) @(negedge clk);
        check_reg(2'd0, 8'h00, "R9 reset status");
        check_reg(2'd1, 8'h00, "R9 reset mask");
        check_reg(2'd2, 8'h00, "R9 reset wen");
        rst_n = 1;
        // R9: pins hold non-idle levels from reset; no flag may result
        wr(2'd1, 8'hFF);
        repeat (6) tick("R9 warm");
        check_reg(2'd0, 8'h00, "R9 no flag after warm-up");

        // R1: each timer event sets its own bit; R4 clear it again
        for (int b = 0; b < 6; b++) begin
            case (b)
                0: tmr_ovf = 1;  1: tmra_ovf = 1; 2: tmrb_ovf = 1;
                3: tmrc_ovf = 1; 4: hpw_unf = 1;  default: lpw_unf = 1;
            endcase
            tick("R1 event");
            check_reg(2'd0, (b == 0) ? 8'h01 : (8'h04 << b), "R1 bit position");
            wr(2'd0, 8'h00);
            tick("R4 clear");
            check_reg(2'd0, 8'h00, "R4 cleared");
        end

        // R2: falling edge sets bit 2 on the third edge, rising does not
        ext_pin = 1; repeat (4) tick("R2 rise");
        check_reg(2'd0, 8'h00, "R2 rising ignored");
        ext_pin = 0;
        tick("R2 lat1"); tick("R2 lat2");
        check_reg(2'd0, 8'h00, "R2 not yet");
        tick("R2 lat3");
        check_reg(2'd0, 8'h04, "R2 falling edge");
        wr(2'd0, 8'hFB); tick("R4 clear ext");

        // R3: one port bit change sets bit 1
        port_in = port_in ^ 8'h10;
        repeat (3) tick("R3 port");
        check_reg(2'd0, 8'h02, "R3 port change");

        // R4: writing ones keeps, writing zeros clears
        tmrb_ovf = 1; tick("R4 set");
        wr(2'd0, 8'hFF); tick("R4 keep");
        check_reg(2'd0, 8'h12, "R4 ones keep");
        wr(2'd0, 8'hEF); tick("R4 partial");
        check_reg(2'd0, 8'h02, "R4 partial clear");

        // R5: set and clear together, set wins
        tmr_ovf = 1; wr(2'd0, 8'h00); tick("R5 collide");
        check_reg(2'd0, 8'h01, "R5 set wins");

        // R6/R7: partial mask, other addresses
        wr(2'd1, 8'h02); tick("R6 mask");
        check_reg(2'd0, 8'h00, "R6 masked read");
        chk("R7 irq masked off", irq, 1'b0);
        wr(2'd2, 8'hFF); tick("R6 wen");
        check_reg(2'd2, 8'h07, "R6 wen upper zero");
        check_reg(2'd3, 8'h00, "R6 addr3 zero");
        check_reg(2'd1, 8'h02, "R6 mask readback");

        // R8: per-source wake gating
        wr(2'd0, 8'h00); tick("R8 clr");
        wr(2'd2, 8'h02); tick("R8 cmp only");
        lvd_evt = 1; #1; chk("R8 lvd disabled", wake_req, 1'b0);
        cmp_evt = 1; #1; chk("R8 cmp enabled", wake_req, 1'b1);
        cmp_evt = 0; wr(2'd2, 8'h04); tick("R8 lvd");
        chk("R8 lvd enabled", wake_req, 1'b1);
        lvd_evt = 0; wr(2'd2, 8'h01); tick("R8 pchg");
        port_in = port_in ^ 8'h01; repeat (3) tick("R8 pchg wait");
        chk("R8 port change wake", wake_req, 1'b1);

        // Random phase against the model
        for (int i = 0; i < 2000; i++) begin
            evs = 6'($urandom) & 6'($urandom);
            {tmr_ovf, tmra_ovf, tmrb_ovf, tmrc_ovf, hpw_unf, lpw_unf} = evs;
            if ($urandom_range(0, 7) == 0) ext_pin = ~ext_pin;
            if ($urandom_range(0, 9) == 0) port_in = port_in ^ (8'h01 << $urandom_range(0, 7));
            cmp_evt = ($urandom_range(0, 3) == 0);
            lvd_evt = ($urandom_range(0, 3) == 0);
            case ($urandom_range(0, 9))
                0, 1, 2: wr(2'd0, 8'($urandom));
                3:       wr(2'd1, 8'($urandom));
                4:       wr(2'd2, 8'($urandom));
                default: ;
            endcase
            tick("R1 R5 random");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule